// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This block sits between a simple host request port and one 256K x 16 extended-data-out DRAM. Each host request carries an 18-bit word address, a read/write flag, two byte enables and, for writes, 16 bits of data. The controller splits the address into a row half and a column half and places them on a shared 9-bit address bus. It then sequences the row strobe, the two byte-lane column strobes, the write enable and the output enable. A read returns its data on a one-cycle response pulse.

An opened row stays open after an access. A later request that falls in the same row gets only a new column cycle. A request to another row first closes the open row and waits out the precharge time. A separate refresh scheduler asks for a refresh cycle. The controller stalls the host, closes any open row and runs a column-before-row refresh, then acknowledges. All strobe spacings are parameters counted in controller clock cycles.

Top module: `edoram_ctrl`

## Requirements
- R1: After reset the row strobe, both column strobes, write enable and output enable are high (inactive), no data lane is driven, `req_ready` is high and `rsp_valid` is low.
- R2: The row half (address bits 17:9) is on `dram_addr` when the row strobe falls. The column half (bits 8:0) is on `dram_addr` when a column strobe falls. Words written to distinct addresses read back independently.
- R3: Byte enable bit 0 selects the lower column strobe and data bits 7:0. Bit 1 selects the upper column strobe and bits 15:8. A write with a single enable leaves the other byte of the stored word unchanged.
- R4: A data lane is driven only while its column strobe is low and write enable is low. With all strobes high, no lane is driven.
- R5: A read keeps write enable high and pulls output enable low. Data is sampled T_CAC cycles after the column strobe falls and returned on a single-cycle `rsp_valid` pulse. Lanes whose enable is 0 read as zero. Responses come back in request order, one per read.
- R6: A column strobe falls no sooner than T_RCD cycles after the row strobe fell. During a host access it stays low for exactly T_CAS cycles.
- R7: A request to the row that is already open is served without raising the row strobe: only a new column address and column pulse are issued.
- R8: A request to a different row raises the row strobe. The row strobe then stays high for at least T_RP cycles before it falls again.
- R9: While `ref_req` is high, `req_ready` is low in every state. The controller closes an open row, precharges, pulls both column strobes low before the row strobe falls, holds the row strobe low for T_RAS cycles, precharges again, and gives a one-cycle `ref_ack`.
- R10: A request with both byte enables 0 makes no column strobe fall and changes no stored data. A read of that kind returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address, row in 17:9, column in 8:0 |
| req_be | input | 2 | Byte enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| ref_req | input | 1 | Refresh wanted by the scheduler |
| ref_ack | output | 1 | Refresh sequence finished (one cycle) |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data toward the DRAM |
| dram_dq_oe | output | 2 | Per-lane drive enable for `dram_dq_out` |
| dram_dq_in | input | 16 | Data from the DRAM |

## Verification
The host side is exercised with runs of accesses inside one row and with accesses that alternate between rows. Counting row-strobe falls shows whether a row was reused or reopened. Full-word, single-lane and empty byte enables are mixed on the same word, so lane steering, merging and the masking of disabled lanes show up in the read-back values. A refresh request arrives while a row is open, which tests the close, the column-before-row order and the stall together. A behavioural DRAM model in the bench measures strobe spacings and illegal bus driving on every cycle.

// File: rtl/edoram_pkg.sv
package edoram_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ACT,
      ST_COL,
      ST_CPRE,
      ST_OPEN,
      ST_PRE,
      ST_RCAS,
      ST_RRAS,
      ST_RPRE
   } seq_state_e;

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/edoram_timer.sv
module edoram_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   output logic [CNT_W-1:0] elapsed
);

   // Cycles spent in the current state; saturates so a long stay cannot wrap.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         elapsed <= '0;
      end else if (restart) begin
         elapsed <= '0;
      end else if (elapsed != {CNT_W{1'b1}}) begin
         elapsed <= elapsed + 1'b1;
      end
   end

endmodule

// File: rtl/edoram_lanes.sv
module edoram_lanes #(
   parameter int unsigned LANE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                drive_wr,
   input  logic                capture,
   input  logic [1:0]          be,
   input  logic [2*LANE_W-1:0] wdata,
   input  logic [2*LANE_W-1:0] dq_in,
   output logic [2*LANE_W-1:0] dq_out,
   output logic [1:0]          dq_oe,
   output logic [2*LANE_W-1:0] rdata,
   output logic                rvalid
);

   assign dq_out = wdata;

   for (genvar g = 0; g < 2; g++) begin : g_lane
      assign dq_oe[g] = drive_wr & be[g];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rdata[g*LANE_W +: LANE_W] <= '0;
         end else if (capture) begin
            rdata[g*LANE_W +: LANE_W] <= be[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rvalid <= 1'b0;
      else        rvalid <= capture;
   end

   AST_LANE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!drive_wr) |-> (dq_oe == 2'b00)); // R4

   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |=> !rvalid); // R5

endmodule

// File: rtl/edoram_seq.sv
module edoram_seq
   import edoram_pkg::*;
#(
   parameter int unsigned ADDR_W = 18,
   parameter int unsigned LANE_W = 8,
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned T_RCD  = 3,
   parameter int unsigned T_CAS  = 2,
   parameter int unsigned T_CP   = 1,
   parameter int unsigned T_RP   = 4,
   parameter int unsigned T_CAC  = 2,
   parameter int unsigned T_CSR  = 1,
   parameter int unsigned T_RAS  = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic                   req_write,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic [1:0]             req_be,
   input  logic [2*LANE_W-1:0]    req_wdata,
   input  logic                   ref_req,
   output logic                   ref_ack,
   input  logic [CNT_W-1:0]       elapsed,
   output logic                   restart,
   output logic [ADDR_W-ADDR_W/2-1:0] dram_addr,
   output logic                   dram_ras_n,
   output logic                   dram_lcas_n,
   output logic                   dram_ucas_n,
   output logic                   dram_we_n,
   output logic                   dram_oe_n,
   output logic                   drive_wr,
   output logic                   capture,
   output logic [1:0]             be_q,
   output logic [2*LANE_W-1:0]    wdata_q
);

   localparam int unsigned ROW_W  = ADDR_W / 2;
   localparam int unsigned COL_W  = ADDR_W - ROW_W;
   localparam int unsigned DATA_W = 2 * LANE_W;

   seq_state_e          state_q, state_d;
   logic                pend_q, pend_d;
   logic [ADDR_W-1:0]   rq_addr_q;
   logic                rq_we_q;
   logic [1:0]          rq_be_q;
   logic [DATA_W-1:0]   rq_wd_q;
   logic [ROW_W-1:0]    row_open_q;
   logic                accept;
   logic                row_hit;
   logic                in_col;
   logic                ref_cas;

   function automatic logic span_done(input logic [CNT_W-1:0] e, input int unsigned n);
      return e == CNT_W'(n - 1);
   endfunction

   assign req_ready = ((state_q == ST_IDLE) || (state_q == ST_OPEN)) && !ref_req;
   assign accept    = req_valid && req_ready;
   assign row_hit   = (req_addr[ADDR_W-1 -: ROW_W] == row_open_q);

   always_comb begin
      state_d = state_q;
      pend_d  = pend_q;
      case (state_q)
         ST_IDLE: begin
            if (ref_req)     state_d = ST_RCAS;
            else if (accept) state_d = ST_ACT;
         end
         ST_ACT:  if (span_done(elapsed, T_RCD)) state_d = ST_COL;
         ST_COL:  if (span_done(elapsed, T_CAS)) state_d = ST_CPRE;
         ST_CPRE: if (span_done(elapsed, T_CP))  state_d = ST_OPEN;
         ST_OPEN: begin
            if (ref_req) begin
               state_d = ST_PRE;
               pend_d  = 1'b0;
            end else if (accept) begin
               if (row_hit) begin
                  state_d = ST_COL;
               end else begin
                  state_d = ST_PRE;
                  pend_d  = 1'b1;
               end
            end
         end
         ST_PRE: begin
            if (span_done(elapsed, T_RP)) begin
               state_d = pend_q ? ST_ACT : ST_IDLE;
               pend_d  = 1'b0;
            end
         end
         ST_RCAS: if (span_done(elapsed, T_CSR)) state_d = ST_RRAS;
         ST_RRAS: if (span_done(elapsed, T_RAS)) state_d = ST_RPRE;
         ST_RPRE: if (span_done(elapsed, T_RP))  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         pend_q  <= pend_d;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rq_addr_q <= '0;
         rq_we_q   <= 1'b0;
         rq_be_q   <= 2'b00;
         rq_wd_q   <= '0;
      end else if (accept) begin
         rq_addr_q <= req_addr;
         rq_we_q   <= req_write;
         rq_be_q   <= req_be;
         rq_wd_q   <= req_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 row_open_q <= '0;
      else if (state_q == ST_ACT) row_open_q <= rq_addr_q[ADDR_W-1 -: ROW_W];
   end

   assign restart = (state_d != state_q);
   assign in_col  = (state_q == ST_COL);
   assign ref_cas = (state_q == ST_RCAS) || (state_q == ST_RRAS);

   assign dram_addr = (in_col || state_q == ST_CPRE) ? rq_addr_q[COL_W-1:0]
                                                     : COL_W'(rq_addr_q[ADDR_W-1 -: ROW_W]);
   assign dram_ras_n  = !((state_q == ST_ACT) || in_col || (state_q == ST_CPRE) ||
                          (state_q == ST_OPEN) || (state_q == ST_RRAS));
   assign dram_lcas_n = !((in_col && rq_be_q[0]) || ref_cas);
   assign dram_ucas_n = !((in_col && rq_be_q[1]) || ref_cas);
   assign dram_we_n   = !(in_col && rq_we_q);
   assign dram_oe_n   = !(in_col && !rq_we_q);

   assign drive_wr = in_col && rq_we_q;
   assign capture  = in_col && !rq_we_q && (elapsed == CNT_W'(T_CAC - 1));
   assign ref_ack  = (state_q == ST_RPRE) && span_done(elapsed, T_RP);
   assign be_q     = rq_be_q;
   assign wdata_q  = rq_wd_q;

   AST_HIT_KEEPS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OPEN && accept && row_hit) |=> (!dram_ras_n && state_q == ST_COL)); // R7

   AST_REF_CLOSES_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OPEN && ref_req) |=> dram_ras_n); // R9

   AST_MISS_CLOSES_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OPEN && accept && !row_hit) |=> dram_ras_n); // R8

endmodule

// File: rtl/edoram_ctrl.sv
module edoram_ctrl
   import edoram_pkg::*;
#(
   parameter int unsigned ADDR_W = 18,
   parameter int unsigned LANE_W = 8,
   parameter int unsigned T_RCD  = 3,
   parameter int unsigned T_CAS  = 2,
   parameter int unsigned T_CP   = 1,
   parameter int unsigned T_RP   = 4,
   parameter int unsigned T_CAC  = 2,
   parameter int unsigned T_CSR  = 1,
   parameter int unsigned T_RAS  = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic                      req_write,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [1:0]                req_be,
   input  logic [2*LANE_W-1:0]       req_wdata,
   output logic                      rsp_valid,
   output logic [2*LANE_W-1:0]       rsp_rdata,
   input  logic                      ref_req,
   output logic                      ref_ack,
   output logic [ADDR_W-ADDR_W/2-1:0] dram_addr,
   output logic                      dram_ras_n,
   output logic                      dram_lcas_n,
   output logic                      dram_ucas_n,
   output logic                      dram_we_n,
   output logic                      dram_oe_n,
   output logic [2*LANE_W-1:0]       dram_dq_out,
   output logic [1:0]                dram_dq_oe,
   input  logic [2*LANE_W-1:0]       dram_dq_in
);

   localparam int unsigned DATA_W = 2 * LANE_W;
   localparam int unsigned T_MAX  = umax(umax(umax(T_RCD, T_CAS), umax(T_CP, T_RP)),
                                         umax(T_CSR, T_RAS));
   localparam int unsigned CNT_W  = $clog2(T_MAX + 1);
   localparam int unsigned HI_W   = $clog2(T_RP + 1);
   localparam int unsigned LO_W   = $clog2(T_RCD + 1);

   if (ADDR_W % 2 != 0) begin : g_bad_addr
      $error("edoram_ctrl: ADDR_W must split into equal row and column halves");
   end
   if (T_RCD < 1 || T_CAS < 1 || T_CP < 1 || T_RP < 1 || T_CSR < 1 || T_RAS < 1) begin : g_bad_time
      $error("edoram_ctrl: every timing span must be at least one cycle");
   end
   if (T_CAC < 1 || T_CAC > T_CAS) begin : g_bad_cac
      $error("edoram_ctrl: T_CAC must fall inside the column pulse");
   end

   logic [CNT_W-1:0]  elapsed;
   logic              restart;
   logic              drive_wr;
   logic              capture;
   logic [1:0]        be_q;
   logic [DATA_W-1:0] wdata_q;

   edoram_seq #(
      .ADDR_W (ADDR_W), .LANE_W (LANE_W), .CNT_W (CNT_W),
      .T_RCD  (T_RCD),  .T_CAS  (T_CAS),  .T_CP  (T_CP),
      .T_RP   (T_RP),   .T_CAC  (T_CAC),  .T_CSR (T_CSR), .T_RAS (T_RAS)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_write   (req_write),
      .req_addr    (req_addr),
      .req_be      (req_be),
      .req_wdata   (req_wdata),
      .ref_req     (ref_req),
      .ref_ack     (ref_ack),
      .elapsed     (elapsed),
      .restart     (restart),
      .dram_addr   (dram_addr),
      .dram_ras_n  (dram_ras_n),
      .dram_lcas_n (dram_lcas_n),
      .dram_ucas_n (dram_ucas_n),
      .dram_we_n   (dram_we_n),
      .dram_oe_n   (dram_oe_n),
      .drive_wr    (drive_wr),
      .capture     (capture),
      .be_q        (be_q),
      .wdata_q     (wdata_q)
   );

   edoram_timer #(.CNT_W (CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .elapsed (elapsed)
   );

   edoram_lanes #(.LANE_W (LANE_W)) u_lanes (
      .clk      (clk),
      .rst_n    (rst_n),
      .drive_wr (drive_wr),
      .capture  (capture),
      .be       (be_q),
      .wdata    (wdata_q),
      .dq_in    (dram_dq_in),
      .dq_out   (dram_dq_out),
      .dq_oe    (dram_dq_oe),
      .rdata    (rsp_rdata),
      .rvalid   (rsp_valid)
   );

   // Pin-level spacing monitors: cycles the row strobe has been high / low.
   logic [HI_W-1:0] ras_hi_cnt;
   logic [LO_W-1:0] ras_lo_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ras_hi_cnt <= HI_W'(T_RP);
         ras_lo_cnt <= '0;
      end else if (dram_ras_n) begin
         ras_lo_cnt <= '0;
         if (ras_hi_cnt != HI_W'(T_RP)) ras_hi_cnt <= ras_hi_cnt + 1'b1;
      end else begin
         ras_hi_cnt <= '0;
         if (ras_lo_cnt != LO_W'(T_RCD)) ras_lo_cnt <= ras_lo_cnt + 1'b1;
      end
   end

   AST_ROW_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dram_ras_n) |-> (ras_hi_cnt == HI_W'(T_RP))); // R8

   AST_ROW_TO_COL: assert property (@(posedge clk) disable iff (!rst_n)
      (!dram_ras_n && ($fell(dram_lcas_n) || $fell(dram_ucas_n))) |-> (ras_lo_cnt == LO_W'(T_RCD))); // R6

   AST_COL_BEFORE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dram_ras_n) && $past(!dram_lcas_n || !dram_ucas_n)) |-> (!dram_lcas_n && !dram_ucas_n)); // R9

   AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_ras_n && dram_lcas_n && dram_ucas_n) |-> (dram_dq_oe == 2'b00)); // R4

   AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req |-> !req_ready); // R9

endmodule

// File: tb/edoram_ctrl_bench.sv
module edoram_ctrl_bench;

   localparam int T_RCD = 3;
   localparam int T_CAS = 2;
   localparam int T_CP  = 1;
   localparam int T_RP  = 4;
   localparam int T_CAC = 2;
   localparam int T_CSR = 1;
   localparam int T_RAS = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [17:0] req_addr = '0;
   logic [1:0]  req_be = 2'b00;
   logic [15:0] req_wdata = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic        ref_req = 1'b0;
   logic        ref_ack;
   logic [8:0]  dram_addr;
   logic        dram_ras_n, dram_lcas_n, dram_ucas_n, dram_we_n, dram_oe_n;
   logic [15:0] dram_dq_out;
   logic [1:0]  dram_dq_oe;
   logic [15:0] dram_dq_in = '0;

   always #5 clk = ~clk;

   edoram_ctrl #(
      .ADDR_W (18), .LANE_W (8), .T_RCD (T_RCD), .T_CAS (T_CAS), .T_CP (T_CP),
      .T_RP (T_RP), .T_CAC (T_CAC), .T_CSR (T_CSR), .T_RAS (T_RAS)
   ) u_edoram_ctrl (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
      .req_addr (req_addr), .req_be (req_be), .req_wdata (req_wdata),
      .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
      .ref_req (ref_req), .ref_ack (ref_ack),
      .dram_addr (dram_addr), .dram_ras_n (dram_ras_n),
      .dram_lcas_n (dram_lcas_n), .dram_ucas_n (dram_ucas_n),
      .dram_we_n (dram_we_n), .dram_oe_n (dram_oe_n),
      .dram_dq_out (dram_dq_out), .dram_dq_oe (dram_dq_oe), .dram_dq_in (dram_dq_in)
   );

   int total = 0;
   int bad = 0;
   int reads_issued = 0;
   int resp_seen = 0;
   logic [15:0] exp_q[$];
   logic [15:0] shadow [int];
   logic [15:0] dmem [int];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- DRAM behavioural model and pin monitor ----------------
   int ras_falls = 0, cas_falls = 0, cbr_cnt = 0;
   int viol_rp = 0, viol_rcd = 0, viol_casw = 0, viol_bus = 0, viol_cbr = 0;
   int hi_run = 100, lo_run = 0;
   int cas_run [2];
   logic prev_ras = 1'b1;
   logic [1:0] prev_cas = 2'b11;
   logic [1:0] cn;
   logic [8:0] row_l = '0, col_l = '0;
   logic [15:0] w;
   int key;

   always @(negedge clk) begin
      if (!rst_n) begin
         prev_ras = 1'b1; prev_cas = 2'b11; hi_run = 100; lo_run = 0;
         cas_run[0] = 0; cas_run[1] = 0;
      end else begin
         cn = {dram_ucas_n, dram_lcas_n};
         if (prev_ras && !dram_ras_n) begin
            ras_falls++;
            if (hi_run < T_RP) viol_rp++;
            if (cn != 2'b11) begin
               cbr_cnt++;
               if (cn != 2'b00) viol_cbr++;
            end else begin
               row_l = dram_addr;
            end
         end
         for (int i = 0; i < 2; i++) begin
            if (!dram_ras_n && prev_cas[i] && !cn[i]) begin
               cas_falls++;
               if (lo_run < T_RCD) viol_rcd++;
               col_l = dram_addr;
               if (!dram_we_n) begin
                  if (dram_dq_oe[i]) begin
                     key = int'({row_l, col_l});
                     w = dmem.exists(key) ? dmem[key] : 16'h0000;
                     w[i*8 +: 8] = dram_dq_out[i*8 +: 8];
                     dmem[key] = w;
                  end else begin
                     viol_bus++;
                  end
               end
            end
            if (!dram_ras_n && !prev_cas[i] && cn[i] && cas_run[i] != T_CAS) viol_casw++;
            if (dram_dq_oe[i] && (cn[i] || dram_we_n)) viol_bus++;
         end
         if (!dram_ras_n && !dram_oe_n) begin
            key = int'({row_l, col_l});
            w = dmem.exists(key) ? dmem[key] : 16'h0000;
            for (int i = 0; i < 2; i++) if (cn[i]) w[i*8 +: 8] = 8'hA5;
            dram_dq_in = w;
         end
         hi_run = dram_ras_n ? hi_run + 1 : 0;
         lo_run = dram_ras_n ? 0 : lo_run + 1;
         for (int i = 0; i < 2; i++) cas_run[i] = cn[i] ? 0 : cas_run[i] + 1;
         prev_ras = dram_ras_n;
         prev_cas = cn;
      end
   end

   // ---------------- Scoreboard monitor ----------------
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         resp_seen++;
         if (exp_q.size() == 0) begin
            chk("R5 unexpected response", 32'(rsp_rdata), 32'hFFFF_FFFF);
         end else begin
            chk("R5 R3 read data", 32'(rsp_rdata), 32'(exp_q.pop_front()));
         end
      end
   end

   // ---------------- Driver ----------------
   function automatic logic [17:0] mk(input int row, input int col);
      return {row[8:0], col[8:0]};
   endfunction

   task automatic host(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
      logic [15:0] cur;
      cur = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
      if (wr) begin
         for (int i = 0; i < 2; i++) if (be[i]) cur[i*8 +: 8] = d[i*8 +: 8];
         shadow[int'(a)] = cur;
      end else begin
         for (int i = 0; i < 2; i++) if (!be[i]) cur[i*8 +: 8] = 8'h00;
         exp_q.push_back(cur);
         reads_issued++;
      end
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic settle();
      repeat (14) @(negedge clk);
   endtask

   bit finished = 1'b0;

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   int f0, c0, ack_cycles;
   bit ready_low_all;

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 ras_n", 32'(dram_ras_n), 32'd1);
      chk("R1 cas_n", 32'({dram_ucas_n, dram_lcas_n}), 32'd3);
      chk("R1 we_n/oe_n", 32'({dram_we_n, dram_oe_n}), 32'd3);
      chk("R1 dq_oe", 32'(dram_dq_oe), 32'd0);
      chk("R1 req_ready", 32'(req_ready), 32'd1);
      chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);

      // R7 page hits within one row, R2 distinct columns
      f0 = ras_falls;
      host(1, mk(3, 5), 16'h1234, 2'b11);
      host(1, mk(3, 6), 16'h9ABC, 2'b11);
      host(0, mk(3, 5), 16'h0, 2'b11);
      host(0, mk(3, 6), 16'h0, 2'b11);
      settle();
      chk("R7 one row open for same-row run", 32'(ras_falls - f0), 32'd1);

      // R3 byte-lane writes merge; R5 disabled lanes read zero
      host(1, mk(3, 5), 16'h55AB, 2'b01);
      host(0, mk(3, 5), 16'h0, 2'b11);
      host(1, mk(3, 5), 16'hCD77, 2'b10);
      host(0, mk(3, 5), 16'h0, 2'b11);
      host(0, mk(3, 5), 16'h0, 2'b01);
      host(0, mk(3, 5), 16'h0, 2'b10);
      settle();
      chk("R7 byte accesses stay in open row", 32'(ras_falls - f0), 32'd1);

      // R10 empty byte enables: no column strobe, no change
      c0 = cas_falls;
      host(1, mk(3, 6), 16'hFFFF, 2'b00);
      host(0, mk(3, 6), 16'h0, 2'b00);
      settle();
      chk("R10 no column strobe fell", 32'(cas_falls - c0), 32'd0);
      host(0, mk(3, 6), 16'h0, 2'b11);
      settle();

      // R8 row misses reopen with precharge; R2 same column different rows
      f0 = ras_falls;
      host(1, mk(7, 5), 16'h5555, 2'b11);
      host(0, mk(3, 5), 16'h0, 2'b11);
      host(0, mk(7, 5), 16'h0, 2'b11);
      settle();
      chk("R8 each row change reopens", 32'(ras_falls - f0), 32'd3);

      // R2 address sweep across rows and columns
      for (int i = 0; i < 8; i++)
         host(1, mk((i * 37 + 1) % 512, (i * 53 + 2) % 512), 16'(i * 16'h1111 ^ 16'hA0A0), 2'b11);
      for (int i = 7; i >= 0; i--)
         host(0, mk((i * 37 + 1) % 512, (i * 53 + 2) % 512), 16'h0, 2'b11);
      settle();

      // R9 refresh while a row is open
      host(0, mk(7, 5), 16'h0, 2'b11);
      settle();
      @(negedge clk);
      ref_req = 1'b1;
      ready_low_all = 1'b1;
      ack_cycles = 0;
      @(negedge clk);
      while (!ref_ack) begin
         if (req_ready) ready_low_all = 1'b0;
         @(negedge clk);
      end
      if (req_ready) ready_low_all = 1'b0;
      ref_req = 1'b0;
      ack_cycles++;
      @(negedge clk);
      if (ref_ack) ack_cycles++;
      chk("R9 host stalled during refresh", 32'(ready_low_all), 32'd1);
      chk("R9 one refresh cycle issued", 32'(cbr_cnt), 32'd1);
      chk("R9 column strobes low before row fell", 32'(viol_cbr), 32'd0);
      chk("R9 ack is one cycle", 32'(ack_cycles), 32'd1);
      f0 = ras_falls;
      host(0, mk(7, 5), 16'h0, 2'b11);
      settle();
      chk("R9 row reopened after refresh", 32'(ras_falls - f0), 32'd1);

      chk("R4 bus driven only in write pulses", 32'(viol_bus), 32'd0);
      chk("R6 row-to-column spacing", 32'(viol_rcd), 32'd0);
      chk("R6 column pulse width", 32'(viol_casw), 32'd0);
      chk("R8 precharge spacing", 32'(viol_rp), 32'd0);
      chk("R5 all reads answered", 32'(resp_seen), 32'(reads_issued));
      chk("R5 scoreboard empty", 32'(exp_q.size()), 32'd0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule